// File: doc/BRIEF.md
# Adaptive Two-Error-Correcting BCH Decoder

This block decodes one 79-bit word of a shortened binary BCH code over GF(2^7) that carries one extra even-parity bit across the whole word. The word holds 64 data bits and 15 check bits and has minimum distance 6. The decoder repairs any pattern of one or two flipped bits. It flags any pattern of three flipped bits as uncorrectable and does not miscorrect it.

Once a word is accepted, the decoder registers the syndromes S1 and S3 and the overall parity. In the next cycle it sorts the word into one of four classes: clean, single error, double error or uncorrectable.

- A clean word finishes in that same cycle.
- A single error is located in that same cycle by a direct compare against every position constant.
- Only the double-error class runs a multi-cycle root search over the error-locator polynomial, so latency depends on the error class.

The search logic reads only registered syndrome copies. Syndrome glitches therefore cannot reach the locator arithmetic. The decoder handles one word at a time. It accepts a word only while idle and returns the result with a one-cycle done strobe.

Top module: `bch_dec_adaptive`

## Requirements
- R1: Word layout.
  - For j in 0..77, bit j of `cw_i` is the coefficient of x^j in a code polynomial that has alpha and alpha^3 as roots, where alpha is a root of x^7+x^3+1.
  - Bit 78 makes the XOR of all 79 bits zero.
  - Data sits in bits 77..14.
  - An error-free word yields `clean_o` with `data_o` equal to `cw_i[77:14]`.
- R2: Any single flipped bit, including the parity bit 78, is repaired: `data_o` equals the error-free data and `corr1_o` is set.
- R3: Any two flipped bits, including one in bit 78, are repaired: `data_o` equals the error-free data and `corr2_o` is set.
- R4: Any three flipped bits set `uncorr_o`, and `data_o` carries the received bits 77..14 unmodified.
- R5: Latency. Count rising edges from the edge that accepts a word.
  - `out_valid_o` is high after edge 2 for the clean, single-error and three-error cases.
  - It is high after edge 3+ceil(78/LANES) for two-error cases. That is edge 13 with LANES=8.
- R6: `in_ready_o` is high only while idle. A word offered while busy is ignored and does not change the pending result.
- R7: Result handshake.
  - `out_valid_o` is a one-cycle pulse.
  - Exactly one of `clean_o`, `corr1_o`, `corr2_o`, `uncorr_o` is high with it.
  - `data_o` and the flags hold their values until the next result.
- R8: Reset state.
  - While `rst_ni` is low the decoder is idle: `in_ready_o`=1, `out_valid_o`=0, all flags 0 and `data_o`=0.
  - A reset during a search abandons that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Decoder idle, word taken on this edge |
| cw_i | input | 79 | Received word |
| out_valid_o | output | 1 | Result pulse |
| data_o | output | 64 | Repaired (or passed-through) data |
| clean_o | output | 1 | No error found |
| corr1_o | output | 1 | One bit repaired |
| corr2_o | output | 1 | Two bits repaired |
| uncorr_o | output | 1 | Error detected, not repaired |

## Verification
The bench targets errors at the edges of the word: bit 0, bits 13 and 14 on either side of the data boundary, bit 77, and the parity bit 78 alone and paired with a BCH-position error. If the parity-plus-one case were handled wrongly, the degenerate locator would yield one root and the word would be reported uncorrectable or miscorrected. Three-bit patterns must not be taken as single errors whose locator matches a shortened-away position; a decoder that flipped a bit anyway would show changed data. Latency is measured per class, which exposes a design that ran the search for every word. Words offered while busy, and a reset in the middle of a search, confirm that a pending result can neither be corrupted nor leak out.

// File: rtl/bch_dec_pkg.sv
package bch_dec_pkg;
  parameter int GF_M     = 7;
  parameter logic [GF_M-1:0] GF_POLY = 7'h09;  // x^7 = x^3 + 1
  parameter int GF_ORDER = (1 << GF_M) - 1;
  parameter int NPOS     = 78;                 // BCH positions
  parameter int K        = 64;
  parameter int NCHK     = NPOS - K;
  parameter int NCW      = NPOS + 1;           // plus overall parity

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYN, ST_CLS, ST_SRCH, ST_DONE
  } dec_st_e;

  // flag order {clean, corr1, corr2, uncorr}
  parameter logic [3:0] FL_CLEAN = 4'b1000;
  parameter logic [3:0] FL_COR1  = 4'b0100;
  parameter logic [3:0] FL_COR2  = 4'b0010;
  parameter logic [3:0] FL_UNC   = 4'b0001;

  function automatic gf_t gf_mul(input gf_t a, input gf_t b);
    gf_t acc, t;
    acc = '0;
    t   = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc ^= t;
      t = {t[GF_M-2:0], 1'b0} ^ (t[GF_M-1] ? GF_POLY : '0);
    end
    return acc;
  endfunction

  function automatic gf_t alpha_pow(input int e);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < (e % GF_ORDER); i++)
      r = {r[GF_M-2:0], 1'b0} ^ (r[GF_M-1] ? GF_POLY : '0);
    return r;
  endfunction
endpackage

// File: rtl/bch_syndrome.sv
module bch_syndrome
  import bch_dec_pkg::*;
(
  input  logic [NCW-1:0] cw_i,
  output gf_t            s1_o,
  output gf_t            s3_o,
  output logic           par_o
);
  gf_t t1 [NPOS];
  gf_t t3 [NPOS];

  for (genvar j = 0; j < NPOS; j++) begin : g_term
    localparam gf_t A1 = alpha_pow(j);
    localparam gf_t A3 = alpha_pow(3 * j);
    assign t1[j] = cw_i[j] ? A1 : '0;
    assign t3[j] = cw_i[j] ? A3 : '0;
  end

  always_comb begin
    s1_o = '0;
    s3_o = '0;
    for (int j = 0; j < NPOS; j++) begin
      s1_o ^= t1[j];
      s3_o ^= t3[j];
    end
  end

  assign par_o = ^cw_i;
endmodule

// File: rtl/bch_single_loc.sv
module bch_single_loc
  import bch_dec_pkg::*;
(
  input  gf_t            s1_i,
  output logic           hit_o,
  output logic [K-1:0]   flip_o
);
  logic [NPOS-1:0] match;

  for (genvar j = 0; j < NPOS; j++) begin : g_cmp
    localparam gf_t AJ = alpha_pow(j);
    assign match[j] = (s1_i == AJ);
  end

  assign hit_o  = |match;
  assign flip_o = match[NPOS-1:NCHK];
endmodule

// File: rtl/bch_pair_search.sv
module bch_pair_search
  import bch_dec_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  gf_t           s1_i,
  input  gf_t           s3_i,
  output logic          done_o,
  output logic [1:0]    nroot_o,
  output logic [K-1:0]  flip_o
);
  localparam int NSTEP = (NPOS + LANES - 1) / LANES;
  localparam int SW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam gf_t A_STEP = alpha_pow(LANES);

  logic           busy_q, done_q;
  logic [SW-1:0]  step_q;
  gf_t            s1_q, c1_q, c0_q;
  gf_t            x_q [LANES];
  logic [LANES-1:0] hit;
  logic [1:0]     nroot_q;
  logic [K-1:0]   flip_q;
  int             hcnt;

  // root test of x*sigma' form: s1*x^2 + s1^2*x + (s1^3+s3) == 0, x = alpha^j
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic ok;
    assign ok = (int'(step_q) * LANES + k) < NPOS;
    assign hit[k] = busy_q && ok &&
      ((gf_mul(s1_q, gf_mul(x_q[k], x_q[k])) ^ gf_mul(c1_q, x_q[k]) ^ c0_q) == '0);
  end

  always_comb begin
    hcnt = 0;
    for (int k = 0; k < LANES; k++) hcnt += int'(hit[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      s1_q    <= '0;
      c1_q    <= '0;
      c0_q    <= '0;
      nroot_q <= '0;
      flip_q  <= '0;
      for (int k = 0; k < LANES; k++) x_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        s1_q    <= s1_i;
        c1_q    <= gf_mul(s1_i, s1_i);
        c0_q    <= gf_mul(gf_mul(s1_i, s1_i), s1_i) ^ s3_i;
        nroot_q <= '0;
        flip_q  <= '0;
        for (int k = 0; k < LANES; k++) x_q[k] <= alpha_pow(k);
      end else if (busy_q) begin
        for (int k = 0; k < LANES; k++) x_q[k] <= gf_mul(x_q[k], A_STEP);
        for (int j = NCHK; j < NPOS; j++)
          if (int'(step_q) == j / LANES && hit[j % LANES]) flip_q[j-NCHK] <= 1'b1;
        nroot_q <= (int'(nroot_q) + hcnt > 3) ? 2'd3 : 2'(int'(nroot_q) + hcnt);
        if (int'(step_q) == NSTEP - 1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign nroot_o = nroot_q;
  assign flip_o  = flip_q;
endmodule

// File: rtl/bch_dec_adaptive.sv
module bch_dec_adaptive
  import bch_dec_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [NCW-1:0] cw_i,
  output logic           out_valid_o,
  output logic [K-1:0]   data_o,
  output logic           clean_o,
  output logic           corr1_o,
  output logic           corr2_o,
  output logic           uncorr_o
);
  dec_st_e        st_q;
  logic [NCW-1:0] cw_q;
  gf_t            s1_w, s3_w, s1_q, s3_q;
  logic           p_w, p_q;
  logic [K-1:0]   data_q;
  logic [3:0]     fl_q;

  logic           sng_hit, srch_start, srch_done;
  logic [K-1:0]   sng_flip, srch_flip, rx_data;
  logic [1:0]     nroot;
  gf_t            cube;
  logic           cube_eq, is_clean, is_single, is_double;

  bch_syndrome i_syn (.cw_i(cw_q), .s1_o(s1_w), .s3_o(s3_w), .par_o(p_w));

  // locators see only the registered syndromes
  bch_single_loc i_sng (.s1_i(s1_q), .hit_o(sng_hit), .flip_o(sng_flip));

  bch_pair_search #(.LANES(LANES)) i_srch (
    .clk_i, .rst_ni,
    .start_i(srch_start), .s1_i(s1_q), .s3_i(s3_q),
    .done_o(srch_done), .nroot_o(nroot), .flip_o(srch_flip)
  );

  assign cube      = gf_mul(gf_mul(s1_q, s1_q), s1_q);
  assign cube_eq   = (cube == s3_q);
  assign is_clean  = !p_q && s1_q == '0 && s3_q == '0;
  assign is_single = p_q && cube_eq;
  assign is_double = !p_q && s1_q != '0;
  assign srch_start = (st_q == ST_CLS) && is_double;
  assign rx_data   = cw_q[NPOS-1:NCHK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cw_q   <= '0;
      s1_q   <= '0;
      s3_q   <= '0;
      p_q    <= 1'b0;
      data_q <= '0;
      fl_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_valid_i) begin
          cw_q <= cw_i;
          st_q <= ST_SYN;
        end
        ST_SYN: begin
          s1_q <= s1_w;
          s3_q <= s3_w;
          p_q  <= p_w;
          st_q <= ST_CLS;
        end
        ST_CLS: begin
          if (is_clean) begin
            data_q <= rx_data;
            fl_q   <= FL_CLEAN;
            st_q   <= ST_DONE;
          end else if (is_single) begin
            // s1==0 here means only the parity bit flipped
            if (s1_q == '0 || sng_hit) begin
              data_q <= rx_data ^ sng_flip;
              fl_q   <= FL_COR1;
            end else begin
              data_q <= rx_data;
              fl_q   <= FL_UNC;
            end
            st_q <= ST_DONE;
          end else if (is_double) begin
            st_q <= ST_SRCH;
          end else begin
            data_q <= rx_data;
            fl_q   <= FL_UNC;
            st_q   <= ST_DONE;
          end
        end
        ST_SRCH: if (srch_done) begin
          // degenerate locator (s3 == s1^3): one BCH error plus parity bit
          if ((cube_eq && nroot == 2'd1) || (!cube_eq && nroot == 2'd2)) begin
            data_q <= rx_data ^ srch_flip;
            fl_q   <= FL_COR2;
          end else begin
            data_q <= rx_data;
            fl_q   <= FL_UNC;
          end
          st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = (st_q == ST_IDLE);
  assign out_valid_o = (st_q == ST_DONE);
  assign data_o      = data_q;
  assign {clean_o, corr1_o, corr2_o, uncorr_o} = fl_q;
endmodule

// File: rtl/bch_dec_chk.sv
module bch_dec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic [63:0] data_o,
  input logic        clean_o,
  input logic        corr1_o,
  input logic        corr2_o,
  input logic        uncorr_o
);
  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones({clean_o, corr1_o, corr2_o, uncorr_o}) == 1);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable({data_o, clean_o, corr1_o, corr2_o, uncorr_o}));

  assert_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && !out_valid_o));

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clean_o, corr1_o, corr2_o, uncorr_o}));
endmodule

bind bch_dec_adaptive bch_dec_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .data_o(data_o),
  .clean_o(clean_o), .corr1_o(corr1_o), .corr2_o(corr2_o), .uncorr_o(uncorr_o)
);

// File: tb/test_bch_dec_adaptive.sv
module test_bch_dec_adaptive;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int LAT_SHORT  = 2;
  localparam int LAT_LONG   = 3 + (78 + LANES - 1) / LANES;

  typedef struct packed {
    logic [63:0] d;
    logic [1:0]  n;
    logic [6:0]  a, b, c;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{64'h0,                  2'd0, 7'd0,  7'd0,  7'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 7'd0,  7'd0,  7'd0},
    '{64'h0123_4567_89AB_CDEF, 2'd1, 7'd0,  7'd0,  7'd0},
    '{64'hDEAD_BEEF_0BAD_F00D, 2'd1, 7'd77, 7'd0,  7'd0},
    '{64'h5555_AAAA_3333_CCCC, 2'd1, 7'd78, 7'd0,  7'd0},
    '{64'h8000_0000_0000_0001, 2'd2, 7'd0,  7'd77, 7'd0},
    '{64'h1234_0000_FFFF_4321, 2'd2, 7'd78, 7'd20, 7'd0},
    '{64'hCAFE_BABE_1357_9BDF, 2'd2, 7'd13, 7'd14, 7'd0},
    '{64'h0F0F_0F0F_F0F0_F0F0, 2'd3, 7'd0,  7'd1,  7'd2},
    '{64'h7777_8888_9999_AAAA, 2'd3, 7'd78, 7'd40, 7'd3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [78:0] cw_i = '0;
  logic        in_ready_o, out_valid_o, clean_o, corr1_o, corr2_o, uncorr_o;
  logic [63:0] data_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  logic [14:0] gen;

  bch_dec_adaptive #(.LANES(LANES)) i_bch_dec_adaptive (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .cw_i,
    .out_valid_o, .data_o, .clean_o, .corr1_o, .corr2_o, .uncorr_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // carry-less product then reduction by x^7+x^3+1
  function automatic logic [6:0] fmul(input logic [6:0] a, input logic [6:0] b);
    logic [12:0] p;
    p = '0;
    for (int i = 0; i < 7; i++) if (b[i]) p ^= 13'(a) << i;
    for (int i = 12; i >= 7; i--) if (p[i]) p ^= 13'b10001001 << (i - 7);
    return p[6:0];
  endfunction

  function automatic logic [6:0] apow(input int e);
    logic [6:0] r;
    r = 7'd1;
    for (int i = 0; i < e % 127; i++) r = fmul(r, 7'd2);
    return r;
  endfunction

  task automatic build_gen();
    logic [6:0] p [8];
    logic [7:0] m3;
    for (int i = 0; i < 8; i++) p[i] = '0;
    p[0] = 7'd1;
    for (int i = 0, e = 3; i < 7; i++, e = (e * 2) % 127) begin
      logic [6:0] bb;
      bb = apow(e);
      for (int k = 7; k >= 0; k--)
        p[k] = fmul(bb, p[k]) ^ ((k > 0) ? p[k-1] : 7'd0);
    end
    for (int k = 0; k < 8; k++) m3[k] = p[k][0];
    gen = '0;
    for (int k = 0; k < 8; k++) if (m3[k]) gen ^= 15'(8'b10001001) << k;
  endtask

  function automatic logic [78:0] encode(input logic [63:0] d);
    logic [13:0] r;
    logic [78:0] w;
    logic fb;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      fb = d[i] ^ r[13];
      r  = {r[12:0], 1'b0};
      if (fb) r ^= gen[13:0];
    end
    w = {1'b0, d, r};
    w[78] = ^w[77:0];
    return w;
  endfunction

  task automatic run_word(input logic [78:0] rx, input int n, input logic [63:0] d0,
                          input bit poke);
    logic [3:0]  ef;
    logic [63:0] ed;
    int          el, lat;
    string       rq;
    unique case (n)
      0: begin ef = 4'b1000; rq = "R1"; end
      1: begin ef = 4'b0100; rq = "R2"; end
      2: begin ef = 4'b0010; rq = "R3"; end
      default: begin ef = 4'b0001; rq = "R4"; end
    endcase
    ed = (n < 3) ? d0 : rx[77:14];
    el = (n == 2) ? LAT_LONG : LAT_SHORT;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    cw_i = rx;
    @(posedge clk_i);
    @(negedge clk_i);
    if (poke) begin
      cw_i = ~rx;
      check("R6 ready low while busy", 80'(in_ready_o), 80'(0));
    end else begin
      in_valid_i = 1'b0;
    end
    lat = 0;
    forever begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      if (lat == 1) in_valid_i = 1'b0;
      if (out_valid_o || lat > 60) break;
    end
    check({rq, " flags"}, 80'({clean_o, corr1_o, corr2_o, uncorr_o}), 80'(ef));
    check({rq, " data"}, 80'(data_o), 80'(ed));
    check("R5 latency", 80'(lat), 80'(el));
  endtask

  function automatic logic [78:0] inject(input logic [78:0] w, input vec_t v);
    logic [78:0] r;
    r = w;
    if (v.n >= 1) r[v.a] = ~r[v.a];
    if (v.n >= 2) r[v.b] = ~r[v.b];
    if (v.n >= 3) r[v.c] = ~r[v.c];
    return r;
  endfunction

  initial begin
    build_gen();
    #(CLK_PERIOD * 2 + 1);
    // R8: reset state
    check("R8 ready in reset", 80'(in_ready_o), 80'(1));
    check("R8 out_valid in reset", 80'(out_valid_o), 80'(0));
    check("R8 flags/data in reset",
          80'({clean_o, corr1_o, corr2_o, uncorr_o, data_o}), 80'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk
    foreach (VECS[i]) begin
      logic [78:0] w;
      w = encode(VECS[i].d);
      run_word(inject(w, VECS[i]), int'(VECS[i].n), VECS[i].d, 1'b0);
    end

    // random patterns
    for (int i = 0; i < 60; i++) begin
      vec_t v;
      v.d = {$urandom(), $urandom()};
      v.n = 2'(i % 4);
      v.a = 7'($urandom_range(78, 0));
      do v.b = 7'($urandom_range(78, 0)); while (v.b == v.a);
      do v.c = 7'($urandom_range(78, 0)); while (v.c == v.a || v.c == v.b);
      run_word(inject(encode(v.d), v), int'(v.n), v.d, 1'b0);
    end

    // R6: words offered while busy are ignored
    begin
      vec_t v;
      v = '{64'hA5A5_5A5A_0000_FFFF, 2'd2, 7'd30, 7'd60, 7'd0};
      run_word(inject(encode(v.d), v), 2, v.d, 1'b1);
      v = '{64'h1111_2222_3333_4444, 2'd1, 7'd50, 7'd0, 7'd0};
      run_word(inject(encode(v.d), v), 1, v.d, 1'b1);
    end

    // R7: result holds after the pulse
    begin
      logic [67:0] snap;
      snap = {clean_o, corr1_o, corr2_o, uncorr_o, data_o};
      repeat (3) @(negedge clk_i);
      check("R7 pulse ended", 80'(out_valid_o), 80'(0));
      check("R7 result held", 80'({clean_o, corr1_o, corr2_o, uncorr_o, data_o}), 80'(snap));
    end

    // R8: reset during a search drops the word
    begin
      vec_t v;
      v = '{64'hFEDC_BA98_7654_3210, 2'd2, 7'd5, 7'd70, 7'd0};
      @(negedge clk_i);
      in_valid_i = 1'b1;
      cw_i = inject(encode(v.d), v);
      @(negedge clk_i);
      in_valid_i = 1'b0;
      repeat (5) @(negedge clk_i);
      rst_ni = 1'b0;
      #1;
      check("R8 ready after mid reset", 80'(in_ready_o), 80'(1));
      check("R8 flags after mid reset",
            80'({clean_o, corr1_o, corr2_o, uncorr_o, data_o}), 80'(0));
      repeat (2) @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (16) begin
        @(negedge clk_i);
        if (out_valid_o) break;
      end
      check("R8 no stale result", 80'(out_valid_o), 80'(0));
      run_word(encode(64'h0BAD_CAFE_0000_0001), 0, 64'h0BAD_CAFE_0000_0001, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule